// File: doc/BRIEF.md
# Serial FIFO Trigger-Level Flag Controller

This block sits inside a serial port between a byte serialiser and the software-facing side. It holds two byte queues, 16 entries each by default: one feeds the transmitter and one collects received bytes. The block compares the fill level of each queue with a threshold chosen from a configuration register. It raises a sticky receive-ready flag when enough bytes have arrived. It raises a sticky transmit-space flag when a transmitted byte leaves the send queue low enough to refill.

Optional flow control gates the start of each transmit byte on an active-low clear-to-send pin. It also drives an active-low request-to-send pin from receive occupancy. The receive threshold table changes with the operating mode, asynchronous or clock-synchronous. Flow control only works in asynchronous mode. Serialisation, baud timing, framing and error detection are outside this block.

Top module: `sfifo_trig_ctrl`

## Requirements
- R1: After reset, both flags are 0, both levels are 0, `rts_n` is 0, and every configuration field is 0.
- R2: A `cfg_we` write loads the receive trigger from `cfg_wdata[1:0]`. In asynchronous mode (`sync_mode`=0), codes 00/01/10/11 select 1/4/8/14 bytes.
- R3: In clock-synchronous mode (`sync_mode`=1), the receive trigger codes 00/01/10/11 select 1/2/8/14 bytes.
- R4: `rx_ready` becomes 1 on the clock edge after `rx_level` is at or above the receive threshold. It then stays 1 until it is cleared.
- R5: The transmit trigger comes from `cfg_wdata[3:2]`. Codes 00/01/10/11 select 8/4/2/0 remaining bytes. `tx_space` becomes 1 on the edge where a transmit pop leaves `tx_level` at or below that number. Pushes never set it.
- R6: A `stat_we` write with bit 0 at 0 clears `rx_ready`, and with bit 1 at 0 clears `tx_space`. Each clear works only if that flag's level condition does not hold, meaning receive level below its threshold, or transmit level above its threshold. A 1 in a bit has no effect.
- R7: Flow control is active when `cfg_wdata[4]` was written as 1 and `sync_mode` is 0. While active, `rts_n` is 1 on the edge after `rx_level` reaches the receive threshold and 0 otherwise. While inactive, `rts_n` is 0.
- R8: While flow control is active, a `tx_req` with `cts_n` high does not pop the transmit queue. While inactive, `cts_n` is ignored.
- R9: Each queue returns bytes in the order they were pushed and holds up to 16 of them. A transmit pop presents its byte on `tx_byte` with `tx_valid` on the next edge. A receive pop presents its byte on `rx_rdata` on the next edge.
- R10: A push to a full queue is dropped, and the matching overflow output pulses high for exactly one cycle.
- R11: A pop from an empty queue leaves the read data unchanged, and the matching underflow output pulses high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 selects clock-synchronous mode |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| stat_we | input | 1 | Status flag clear strobe |
| stat_wdata | input | 2 | Write-zero clear bits: [0] receive, [1] transmit |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Transmit byte to push |
| tx_req | input | 1 | Serialiser asks to start the next byte |
| tx_valid | output | 1 | A transmit byte was taken on the last edge |
| tx_byte | output | 8 | Byte taken from the transmit queue |
| rx_push | input | 1 | Push a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Pop from the receive queue |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_level | output | 5 | Receive queue occupancy |
| rx_ready | output | 1 | Sticky receive trigger flag |
| tx_space | output | 1 | Sticky transmit trigger flag |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_ovf | output | 1 | Transmit overflow pulse |
| tx_udf | output | 1 | Transmit underflow pulse |
| rx_ovf | output | 1 | Receive overflow pulse |
| rx_udf | output | 1 | Receive underflow pulse |

## Verification
The assertions assume every strobe and pin input changes only between clock edges and is never X after reset. The stimulus meets this by driving all inputs on the falling edge. The flag properties also assume software never clears and the level condition never flips in a way that races the same edge. This holds because the bench separates clears from pushes and pops by at least one cycle. A scoreboard queue mirrors each byte queue, including dropped pushes, so read order and data are checked as the design produces them.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int DATA_W = 8;

    // configuration write bit positions
    localparam int CFG_RXT_LSB = 0;
    localparam int CFG_TXT_LSB = 2;
    localparam int CFG_MDM_BIT = 4;

    typedef struct packed {
        logic [1:0] rx_trig;
        logic [1:0] tx_trig;
        logic       mdm_en;
    } ctrl_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          ovf,
    output logic          udf
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
        logic [W-1:0]            rdat;
        logic                    ovf;
        logic                    udf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic do_push, do_pop;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.udf = 1'b0;
        do_push  = push && (st_q.cnt != CW'(DEPTH));
        do_pop   = pop && (st_q.cnt != '0);
        if (push && !do_push) st_d.ovf = 1'b1;
        if (pop && !do_pop)   st_d.udf = 1'b1;
        if (do_pop) begin
            st_d.rdat = st_q.mem[st_q.rd];
            st_d.rd   = ptr_inc(st_q.rd);
        end
        if (do_push) begin
            st_d.mem[st_q.wr] = wdata;
            st_d.wr           = ptr_inc(st_q.wr);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdat;
    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;
    assign udf   = st_q.udf;

    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt == CW'(DEPTH)) |=> (ovf && count == CW'(DEPTH)));

    a_r11_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && st_q.cnt == '0) |=> (udf && $stable(rdata)));
endmodule

// File: rtl/trig_thresh.sv
module trig_thresh #(
    parameter int CW = 5
) (
    input  logic          sync_mode,
    input  logic [1:0]    rx_code,
    input  logic [1:0]    tx_code,
    output logic [CW-1:0] rx_thr,
    output logic [CW-1:0] tx_thr
);
    always_comb begin
        case (rx_code)
            2'd0:    rx_thr = CW'(1);
            2'd1:    rx_thr = sync_mode ? CW'(2) : CW'(4);
            2'd2:    rx_thr = CW'(8);
            default: rx_thr = CW'(14);
        endcase
        case (tx_code)
            2'd0:    tx_thr = CW'(8);
            2'd1:    tx_thr = CW'(4);
            2'd2:    tx_thr = CW'(2);
            default: tx_thr = CW'(0);
        endcase
    end
endmodule

// File: rtl/sfifo_trig_ctrl.sv
module sfifo_trig_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              stat_we,
    input  logic [1:0]        stat_wdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_req,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CW-1:0]     tx_level,
    output logic [CW-1:0]     rx_level,
    output logic              rx_ready,
    output logic              tx_space,
    input  logic              cts_n,
    output logic              rts_n,
    output logic              tx_ovf,
    output logic              tx_udf,
    output logic              rx_ovf,
    output logic              rx_udf
);
    typedef struct packed {
        ctrl_t cfg;
        logic  rx_rdy;
        logic  tx_spc;
        logic  rts;
        logic  tx_vld;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CW-1:0] rx_thr, tx_thr;
    logic          mdm_on, tx_take, rx_hit, tx_low, tx_pop_low;
    logic          clr_rx, clr_tx;

    trig_thresh #(.CW(CW)) u_thr (
        .sync_mode (sync_mode),
        .rx_code   (st_q.cfg.rx_trig),
        .tx_code   (st_q.cfg.tx_trig),
        .rx_thr    (rx_thr),
        .tx_thr    (tx_thr)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk (clk), .rst_n (rst_n),
        .push (tx_push), .wdata (tx_wdata),
        .pop (tx_take), .rdata (tx_byte),
        .count (tx_level), .ovf (tx_ovf), .udf (tx_udf)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk (clk), .rst_n (rst_n),
        .push (rx_push), .wdata (rx_wdata),
        .pop (rx_pop), .rdata (rx_rdata),
        .count (rx_level), .ovf (rx_ovf), .udf (rx_udf)
    );

    always_comb begin
        st_d        = st_q;
        mdm_on      = st_q.cfg.mdm_en && !sync_mode;
        tx_take     = tx_req && (!mdm_on || !cts_n);
        rx_hit      = rx_level >= rx_thr;
        tx_low      = tx_level <= tx_thr;
        tx_pop_low  = tx_take && (tx_level != '0) && ((tx_level - 1'b1) <= tx_thr);
        clr_rx      = stat_we && !stat_wdata[0] && !rx_hit;
        clr_tx      = stat_we && !stat_wdata[1] && !tx_low;

        if (cfg_we) begin
            st_d.cfg.rx_trig = cfg_wdata[CFG_RXT_LSB +: 2];
            st_d.cfg.tx_trig = cfg_wdata[CFG_TXT_LSB +: 2];
            st_d.cfg.mdm_en  = cfg_wdata[CFG_MDM_BIT];
        end

        if (rx_hit)      st_d.rx_rdy = 1'b1;
        else if (clr_rx) st_d.rx_rdy = 1'b0;

        if (tx_pop_low)  st_d.tx_spc = 1'b1;
        else if (clr_tx) st_d.tx_spc = 1'b0;

        st_d.rts    = mdm_on && rx_hit;
        st_d.tx_vld = tx_take && (tx_level != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_ready = st_q.rx_rdy;
    assign tx_space = st_q.tx_spc;
    assign rts_n    = st_q.rts;
    assign tx_valid = st_q.tx_vld;

    a_r4_rx_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !(stat_we && !stat_wdata[0])) |=> rx_ready);

    a_r6_no_clear_while_met: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= rx_thr) |=> rx_ready);

    a_r7_rts_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mdm_on |=> !rts_n);

    a_r8_cts_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (mdm_on && cts_n) |=> !tx_valid);

    a_r5_push_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_space && !tx_req) |=> !tx_space);
endmodule

// File: tb/tb_sfifo_trig_ctrl.sv
module tb_sfifo_trig_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       stat_we = 1'b0;
    logic [1:0] stat_wdata = '1;
    logic       tx_push = 1'b0, tx_req = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0;
    logic       cts_n = 1'b1;
    logic       tx_valid, rx_ready, tx_space, rts_n, tx_ovf, tx_udf, rx_ovf, rx_udf;
    logic [7:0] tx_byte, rx_rdata;
    logic [4:0] tx_level, rx_level;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [7:0] rx_last = 8'h00;

    always #2.5 clk = ~clk;

    sfifo_trig_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_req(tx_req),
        .tx_valid(tx_valid), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .tx_level(tx_level), .rx_level(rx_level),
        .rx_ready(rx_ready), .tx_space(tx_space),
        .cts_n(cts_n), .rts_n(rts_n),
        .tx_ovf(tx_ovf), .tx_udf(tx_udf), .rx_ovf(rx_ovf), .rx_udf(rx_udf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clr(input logic [1:0] v);
        stat_we = 1'b1; stat_wdata = v;
        @(negedge clk);
        stat_we = 1'b0; stat_wdata = '1;
    endtask

    task automatic rx_put(input logic [7:0] b);
        rx_push = 1'b1; rx_wdata = b;
        if (rxq.size() < 16) rxq.push_back(b);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic rx_get();
        logic [7:0] e;
        e = (rxq.size() != 0) ? rxq.pop_front() : rx_last;
        rx_last = e;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        chk("R9 rx order", int'(rx_rdata), int'(e));
    endtask

    task automatic tx_put(input logic [7:0] b);
        tx_push = 1'b1; tx_wdata = b;
        txq.push_back(b);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic tx_go();
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    // scoreboard monitor: transmit bytes leave in push order (R9)
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (txq.size() == 0) chk("R9 tx unexpected byte", 1, 0);
            else                 chk("R9 tx order", int'(tx_byte), int'(txq.pop_front()));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 tx_space", tx_space, 0);
        chk("R1 rts_n", rts_n, 0);
        chk("R1 levels", tx_level + rx_level, 0);

        // R2 async code 01 -> 4 bytes
        cfg(8'h01);
        rx_put(8'h11); rx_put(8'h22); rx_put(8'h33);
        cyc(1);
        chk("R2 below 4", rx_ready, 0);
        rx_put(8'h44);
        cyc(1);
        chk("R2 at 4", rx_ready, 1);
        repeat (4) rx_get();
        chk("R4 sticky after drain", rx_ready, 1);
        clr(2'b10);
        chk("R6 clear when unmet", rx_ready, 0);

        // R2 code 00 -> 1 byte
        cfg(8'h00);
        rx_put(8'h55);
        cyc(1);
        chk("R2 code00 one byte", rx_ready, 1);
        rx_get();
        clr(2'b10);

        // R3 sync mode code 01 -> 2 bytes
        cfg(8'h01);
        rx_put(8'hA0); rx_put(8'hA1);
        cyc(1);
        chk("R3 async 2 of 4", rx_ready, 0);
        sync_mode = 1'b1;
        cyc(2);
        chk("R3 sync 2 of 2", rx_ready, 1);
        clr(2'b10);
        cyc(1);
        chk("R6 clear ignored while met", rx_ready, 1);
        rx_get(); rx_get();
        clr(2'b11);
        chk("R6 write-one no effect", rx_ready, 1);
        clr(2'b10);
        chk("R6 cleared", rx_ready, 0);
        sync_mode = 1'b0;

        // R2 code 11 -> 14 bytes, then overflow R10
        cfg(8'h03);
        for (int i = 0; i < 13; i++) rx_put(8'(i + 1));
        cyc(1);
        chk("R2 13 of 14", rx_ready, 0);
        rx_put(8'd14);
        cyc(1);
        chk("R2 14 of 14", rx_ready, 1);
        rx_put(8'd15); rx_put(8'd16);
        chk("R9 depth 16", rx_level, 16);
        rx_put(8'hEE);
        chk("R10 rx_ovf pulse", rx_ovf, 1);
        chk("R10 level held", rx_level, 16);
        cyc(1);
        chk("R10 one cycle", rx_ovf, 0);
        repeat (16) rx_get();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        chk("R11 rx_udf pulse", rx_udf, 1);
        chk("R11 data held", rx_rdata, 16);
        clr(2'b10);

        // R5 transmit trigger code 01 -> 4 remaining
        cfg(8'h04);
        for (int i = 0; i < 6; i++) tx_put(8'(8'h60 + i));
        chk("R5 push does not set", tx_space, 0);
        tx_go();
        chk("R5 five left", tx_space, 0);
        tx_go();
        chk("R5 four left", tx_space, 1);
        repeat (4) tx_go();
        chk("R9 tx drained", tx_level, 0);

        // R5 code 11 -> 0 remaining
        cfg(8'h0C);
        tx_put(8'h71); tx_put(8'h72); tx_put(8'h73);
        clr(2'b01);
        chk("R6 tx clear when above", tx_space, 0);
        tx_go(); tx_go();
        chk("R5 one left code11", tx_space, 0);
        tx_go();
        chk("R5 zero left code11", tx_space, 1);

        // R7/R8 flow control
        cfg(8'h11);
        cts_n = 1'b1;
        tx_put(8'hC1); tx_put(8'hC2);
        tx_go();
        cyc(1);
        chk("R8 cts high blocks", tx_level, 2);
        cts_n = 1'b0;
        tx_go();
        chk("R8 cts low starts", tx_level, 1);
        rx_put(8'hD1); rx_put(8'hD2); rx_put(8'hD3);
        cyc(1);
        chk("R7 rts below thr", rts_n, 0);
        rx_put(8'hD4);
        cyc(1);
        chk("R7 rts at thr", rts_n, 1);
        sync_mode = 1'b1;
        cyc(1);
        chk("R7 rts forced low in sync", rts_n, 0);
        cts_n = 1'b1;
        tx_go();
        chk("R8 cts ignored when off", tx_level, 0);
        sync_mode = 1'b0;
        repeat (4) rx_get();
        cyc(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule